// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable model of a 36-bit synchronous static memory. Its pipeline is arranged so that a read and a write can follow each other on every clock with no idle bus cycle. On each rising clock edge the block samples an address, a load/advance control, an active-low write enable, four active-low byte write strobes, three chip selects and an active-low clock enable. The data bus is bidirectional and is split into four 9-bit lanes. Lane i occupies bits 9i+8 down to 9i: eight data bits and one parity bit.

A host starts an access with a load cycle. It then either loads a new address on each cycle or steps a two-bit burst counter through the four words of an aligned group. Read data is driven out one enabled clock after the address cycle and is sampled by the host on the second enabled edge. Write data is taken from the bus on that same second edge, so both directions use the bus slot in the same position. Holding the clock enable high stretches the current cycle: the pipeline, the counter and the bus all stay as they are.

The control state machine has three states. ST_IDLE means deselected. ST_READ and ST_WRITE mean a read or write burst is in progress. The transitions, all taken only on an enabled edge, are:
- load-select: a load with the chip selects asserted goes to ST_READ or ST_WRITE, according to the write enable.
- load-deselect: a load with the chip selects not asserted goes to ST_IDLE.
- advance: from ST_READ or ST_WRITE, the state is kept and the counter steps.
- advance-in-idle: from ST_IDLE, the state stays ST_IDLE and nothing is issued.

Top module: `sram_zbt_top`

## Requirements
- R1: A read loaded at enabled edge E0 drives the stored word on dq from just after the next enabled edge E1 until the edge E2 after it, provided oe_n is low.
- R2: With adv_ld high on an enabled edge in ST_READ or ST_WRITE, the two low address bits step by one modulo 4 (3 wraps to 0). The upper bits are kept, and the operation type is the one captured at the last load.
- R3: With adv_ld high on an enabled edge in ST_IDLE, no access starts: nothing is read, nothing is written, and dq stays undriven.
- R4: An edge with cen_n high changes nothing. Inputs are ignored, no write occurs, and dq keeps its current value or stays undriven.
- R5: A load selects the device only when ce1_n is 0, ce2 is 1 and ce3_n is 0. Every other combination on a load cycle deselects the device (ST_IDLE). The chip selects are ignored on advance cycles.
- R6: A write loaded at E0 takes dq at the second enabled edge E2. Only the lanes whose bw_n bit, sampled with that address, is 0 are written. Bit i of bw_n gates bits 9i+8 down to 9i.
- R7: oe_n acts without waiting for a clock. While oe_n is high, dq is not driven by the block.
- R8: dq is not driven during a write's data cycle, on the first cycle after a load out of deselect, or while the device is deselected, whatever oe_n is.
- R9: A read issued one cycle after a write to the same address returns that write's lanes merged over the stored word.
- R10: After reset, the state is ST_IDLE and dq is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cen_n | input | 1 | Active-low clock enable; high freezes the cycle |
| adv_ld | input | 1 | 0 = load new address and command; 1 = burst advance |
| we_n | input | 1 | Active-low write command, sampled on load cycles |
| bw_n | input | LANES (4) | Active-low per-lane write strobes |
| ce1_n | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce3_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW (4) | Word address; two low bits seed the burst counter |
| dq | inout | LANES*LANE_W (36) | Bidirectional data bus, four 9-bit lanes |

## Verification
The hardest case is a read that overtakes a write still in flight. The read enters the pipeline while the earlier write's data is only now on the bus, and the stall and deselect paths have to interleave with that. The stimulus reaches it by writing an address with every one of the sixteen lane masks and then reading the same address on the very next cycle. It also inserts clock-enable stalls between a write's address and its data, and deselects in the middle of a burst before reloading. Every bus sample is compared with a reference array that the bench updates only when modelled write data lands.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_t;
endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          adv,
    input  logic          we_n,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    output logic          iss_v,
    output logic          iss_wr,
    output logic [AW-1:0] iss_addr
);
    localparam int HW = AW - BURST_W;

    state_t             state, nxt_state;
    logic [BURST_W-1:0] cnt, nxt_cnt;
    logic [HW-1:0]      base, nxt_base;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            base  <= '0;
        end else if (ce) begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            base  <= nxt_base;
        end
    end

    // next state and issued operation
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_base  = base;
        iss_v     = 1'b0;
        iss_wr    = 1'b0;
        iss_addr  = {base, cnt};
        if (ce) begin
            if (!adv) begin
                if (sel) begin
                    nxt_state = we_n ? ST_READ : ST_WRITE;
                    nxt_base  = addr[AW-1:BURST_W];
                    nxt_cnt   = addr[BURST_W-1:0];
                    iss_v     = 1'b1;
                    iss_wr    = !we_n;
                    iss_addr  = addr;
                end else begin
                    nxt_state = ST_IDLE;
                end
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_READ, ST_WRITE: begin
                        nxt_cnt  = cnt + 1'b1;
                        iss_v    = 1'b1;
                        iss_wr   = (state == ST_WRITE);
                        iss_addr = {base, BURST_W'(cnt + 1'b1)};
                    end
                    default: ;
                endcase
            end
        end
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && adv && state != ST_IDLE) |=> (cnt == BURST_W'($past(cnt) + 1)));

    p_idle_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && adv && state == ST_IDLE) |=> (state == ST_IDLE));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce) |=> ($stable(state) && $stable(cnt) && $stable(base)));

    p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !adv && !sel) |=> (state == ST_IDLE));
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe #(
    parameter int AW    = 4,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             iss_v,
    input  logic             iss_wr,
    input  logic [AW-1:0]    iss_addr,
    input  logic [LANES-1:0] iss_bwn,
    output logic             s1_v,
    output logic             s1_wr,
    output logic [AW-1:0]    s1_addr,
    output logic             s2_v,
    output logic             s2_wr,
    output logic [AW-1:0]    s2_addr,
    output logic [LANES-1:0] s2_bwn
);
    logic [LANES-1:0] s1_bwn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_wr   <= 1'b0;
            s1_addr <= '0;
            s1_bwn  <= '1;
            s2_v    <= 1'b0;
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_bwn  <= '1;
        end else if (ce) begin
            s1_v    <= iss_v;
            s1_wr   <= iss_wr;
            s1_addr <= iss_addr;
            s1_bwn  <= iss_bwn;
            s2_v    <= s1_v;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_bwn  <= s1_bwn;
        end
    end

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce) |=> ($stable(s1_v) && $stable(s2_v) && $stable(s1_addr) && $stable(s2_addr)));
endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int DEPTH  = 16,
    parameter int AW     = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic                    s1_v,
    input  logic                    s1_wr,
    input  logic [AW-1:0]           s1_addr,
    input  logic                    s2_v,
    input  logic                    s2_wr,
    input  logic [AW-1:0]           s2_addr,
    input  logic [LANES-1:0]        s2_bwn,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] out_q,
    output logic                    out_v
);
    localparam int W = LANES * LANE_W;

    logic [W-1:0]     mem [DEPTH];
    logic [W-1:0]     rd_word;
    logic [LANES-1:0] merge_sel;
    logic             wr_now;
    logic             rd_now;

    assign wr_now = ce && s2_v && s2_wr;
    assign rd_now = s1_v && !s1_wr;

    // read path: stored word with the write landing at this edge merged per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merge_sel[g] = s2_v && s2_wr && !s2_bwn[g] && (s2_addr == s1_addr);
        assign rd_word[g*LANE_W +: LANE_W] = merge_sel[g] ? din[g*LANE_W +: LANE_W]
                                                          : mem[s1_addr][g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_now) begin
            for (int i = 0; i < LANES; i++) begin
                if (!s2_bwn[i]) begin
                    mem[s2_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else if (ce) begin
            out_v <= rd_now;
            if (rd_now) begin
                out_q <= rd_word;
            end
        end
    end

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && rd_now && s2_v && s2_wr && (s2_addr == s1_addr) && !s2_bwn[0])
        |=> (out_q[LANE_W-1:0] == $past(din[LANE_W-1:0])));
endmodule

// File: rtl/sram_zbt_top.sv
module sram_zbt_top #(
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen_n,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    inout  wire  [W-1:0]     dq
);
    logic          ce, sel;
    logic          iss_v, iss_wr;
    logic [AW-1:0] iss_addr;
    logic          s1_v, s1_wr, s2_v, s2_wr;
    logic [AW-1:0] s1_addr, s2_addr;
    logic [LANES-1:0] s2_bwn;
    logic [W-1:0]  out_q;
    logic          out_v;

    assign ce  = !cen_n;
    assign sel = !ce1_n && ce2 && !ce3_n;

    sram_ctrl_fsm #(.AW(AW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .adv(adv_ld), .we_n(we_n), .sel(sel),
        .addr(addr), .iss_v(iss_v), .iss_wr(iss_wr), .iss_addr(iss_addr)
    );

    sram_pipe #(.AW(AW), .LANES(LANES)) pipe_i (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .iss_v(iss_v), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_bwn(bw_n),
        .s1_v(s1_v), .s1_wr(s1_wr), .s1_addr(s1_addr),
        .s2_v(s2_v), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bwn(s2_bwn)
    );

    sram_store #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) store_i (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .s1_v(s1_v), .s1_wr(s1_wr), .s1_addr(s1_addr),
        .s2_v(s2_v), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bwn(s2_bwn),
        .din(dq), .out_q(out_q), .out_v(out_v)
    );

    assign dq = (out_v && !oe_n) ? out_q : 'z;

    p_quiet_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && s2_wr) |-> !out_v);
endmodule

// File: tb/sram_zbt_top_tb_top.sv
module sram_zbt_top_tb_top;
    typedef struct {
        bit        v;
        bit        wr;
        bit [3:0]  a;
        bit [3:0]  bw;
        bit [35:0] d;
    } op_t;

    logic clk = 0, rst_n = 0;
    logic cen_n = 1, adv_ld = 0, we_n = 1, ce1_n = 1, ce2 = 0, ce3_n = 1, oe_n = 1;
    logic [3:0] bw_n = '1, addr = '0;
    logic [35:0] tb_wd = '0;
    logic tb_drv = 0;
    wire  [35:0] dq;

    assign dq = tb_drv ? tb_wd : 'z;
    always #5 clk = ~clk;

    sram_zbt_top dut_i (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld), .we_n(we_n),
        .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n),
        .addr(addr), .dq(dq)
    );

    int n_cmp = 0, n_bad = 0, k = 0;
    bit done = 0;
    logic [35:0] ref_mem [16];
    int mst = 0;
    bit [1:0] mcnt = 0, mbase = 0;
    op_t m1, m2;
    bit ev = 0;
    logic [35:0] ed = '0;

    function automatic bit [35:0] pat(int n);
        bit [35:0] r;
        for (int i = 0; i < 4; i++) r[i*9 +: 9] = 9'(n * 13 + i * 101 + 5);
        return r;
    endfunction

    task automatic check(string tag);
        logic [35:0] expv;
        if (tb_drv) expv = tb_wd;
        else if (ev && !oe_n) expv = ed;
        else expv = 'z;
        n_cmp++;
        if (dq !== expv) begin
            n_bad++;
            $display("FAIL %s: dq=%h expected=%h", tag, dq, expv);
        end
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic cyc(bit en, bit adv, bit wen, bit [3:0] bwn, bit [2:0] cs,
                       bit [3:0] a, bit oen, string tag);
        op_t iss;
        iss = '{default: 0};
        cen_n = !en; adv_ld = adv; we_n = wen; bw_n = bwn;
        {ce1_n, ce2, ce3_n} = cs; addr = a; oe_n = oen;
        @(posedge clk);
        if (en) begin
            if (m2.v && m2.wr)
                for (int i = 0; i < 4; i++)
                    if (!m2.bw[i]) ref_mem[m2.a][i*9 +: 9] = m2.d[i*9 +: 9];
            ev = m1.v && !m1.wr;
            if (ev) ed = ref_mem[m1.a];
            if (!adv) begin
                if (cs == 3'b010) begin
                    mst = wen ? 1 : 2; mbase = a[3:2]; mcnt = a[1:0];
                    iss.v = 1; iss.wr = !wen; iss.a = a; iss.bw = bwn;
                end else mst = 0;
            end else if (mst != 0) begin
                mcnt = mcnt + 2'd1;
                iss.v = 1; iss.wr = (mst == 2); iss.a = {mbase, mcnt}; iss.bw = bwn;
            end
            if (iss.v && iss.wr) begin iss.d = pat(k); k++; end
            m2 = m1; m1 = iss;
        end
        @(negedge clk);
        tb_drv = m2.v && m2.wr;
        tb_wd  = m2.d;
        #1;
        check(tag);
    endtask

    task automatic flush(string tag);
        cyc(1, 0, 1, 4'hF, 3'b000, 0, 0, tag);
        cyc(1, 0, 1, 4'hF, 3'b000, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: expired, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m1 = '{default: 0}; m2 = '{default: 0};
        @(negedge clk); @(negedge clk);
        check("R10 reset");
        rst_n = 1;
        @(negedge clk); #1;
        check("R10 after reset");

        // R6: fill every word with full-lane writes
        for (int a = 0; a < 16; a++) cyc(1, 0, 0, 4'h0, 3'b010, 4'(a), 0, "R6 fill");
        flush("R8 flush");
        // R1: single reads of every word
        for (int a = 0; a < 16; a++) cyc(1, 0, 1, 4'hF, 3'b010, 4'(a), 0, "R1 read");
        flush("R8 flush");

        // R2: write and read bursts from every start offset, wrapping modulo 4
        for (int b = 0; b < 4; b++)
            for (int o = 0; o < 4; o++) begin
                cyc(1, 0, 0, 4'h0, 3'b010, 4'(b * 4 + o), 0, "R2 wburst load");
                for (int s = 0; s < 3; s++) cyc(1, 1, 1, 4'h0, 3'b000, 0, 0, "R2 wburst adv");
                cyc(1, 0, 1, 4'hF, 3'b010, 4'(b * 4 + o), 0, "R2 rburst load");
                for (int s = 0; s < 3; s++) cyc(1, 1, 0, 4'hF, 3'b000, 0, 0, "R2 rburst adv");
            end
        flush("R8 flush");

        // R6 and R9: partial-lane writes, alternating with reads, same-address bypass
        for (int a = 0; a < 16; a++) begin
            cyc(1, 0, 0, 4'(a), 3'b010, 4'(a), 0, "R6 partial write");
            cyc(1, 0, 1, 4'hF, 3'b010, 4'(a), 0, "R9 bypass read");
            cyc(1, 0, 0, 4'(~a), 3'b010, 4'(a ^ 5), 0, "R6 partial write");
            cyc(1, 0, 1, 4'hF, 3'b010, 4'(a ^ 5), 0, "R9 bypass read");
            cyc(1, 0, 1, 4'hF, 3'b010, 4'(a ^ 9), 0, "R1 read");
        end
        flush("R8 flush");

        // R4: stalls with junk inputs between address, data and output cycles
        for (int a = 0; a < 16; a += 3) begin
            cyc(1, 0, 0, 4'h6, 3'b010, 4'(a), 0, "R4 write load");
            for (int s = 0; s < 2; s++) cyc(0, 0, 0, 4'h0, 3'b010, 4'(a + 1), 0, "R4 stall");
            cyc(1, 0, 1, 4'hF, 3'b010, 4'(a), 0, "R4 read load");
            for (int s = 0; s < 3; s++) cyc(0, 0, 0, 4'h0, 3'b000, 4'(a + 2), 0, "R4 stall");
            cyc(1, 1, 1, 4'hF, 3'b000, 0, 0, "R4 adv");
            cyc(0, 1, 1, 4'hF, 3'b000, 0, 0, "R4 stall");
            cyc(1, 0, 1, 4'hF, 3'b000, 0, 0, "R4 deselect");
        end
        flush("R8 flush");

        // R5, R3, R8: each non-select combination, advance while idle, reload
        for (int c = 0; c < 8; c++) begin
            if (c == 2) continue;
            cyc(1, 0, 1, 4'hF, 3'b010, 4'(c), 0, "R1 read");
            cyc(1, 0, 1, 4'hF, 3'(c), 4'(c + 1), 0, "R5 deselect mid");
            cyc(1, 0, 0, 4'h0, 3'(c), 4'(c + 2), 0, "R5 deselect");
            cyc(1, 1, 0, 4'h0, 3'b010, 4'(c + 3), 0, "R3 adv idle");
            cyc(1, 1, 1, 4'h0, 3'b010, 4'(c + 4), 0, "R3 adv idle");
            cyc(1, 0, 1, 4'hF, 3'b010, 4'(c + 5), 0, "R8 first after deselect");
            cyc(1, 1, 1, 4'hF, 3'b000, 0, 0, "R5 adv ignores selects");
            cyc(1, 1, 1, 4'hF, 3'b101, 0, 0, "R5 adv ignores selects");
        end
        flush("R8 flush");
        // verify advance-in-idle wrote nothing
        for (int a = 0; a < 16; a++) cyc(1, 0, 1, 4'hF, 3'b010, 4'(a), 0, "R3 readback");
        flush("R8 flush");

        // R7: output enable high during read data and mid-cycle toggling
        cyc(1, 0, 1, 4'hF, 3'b010, 4'd7, 1, "R7 oe high");
        cyc(1, 1, 1, 4'hF, 3'b000, 0, 1, "R7 oe high");
        cyc(1, 1, 1, 4'hF, 3'b000, 0, 0, "R7 oe low");
        oe_n = 1; #1; check("R7 async off");
        oe_n = 0; #1; check("R7 async on");
        cyc(1, 0, 0, 4'h0, 3'b010, 4'd3, 0, "R8 write phase");
        cyc(1, 0, 0, 4'h0, 3'b010, 4'd4, 0, "R8 write phase");
        flush("R8 flush");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule